// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block sits between the pipeline's exception arbiter and the fetch unit. Each cycle it may receive one exception request that has already been prioritised. A request carries a kind, a five-bit cause code, the PC of the faulting instruction, a flag that says whether that instruction sat in a branch delay slot, the current Status, Cause and Debug register values, and the debug-mode flag. From these the block works out four things: the return address to save, the new contents of Status, Cause and Debug, whether debug mode is entered, and the PC to fetch next.

Requests fall into three classes, and each class has its own save register and vector. Normal exceptions save to the exception return register and raise the exception-level flag. Reset and non-maskable error exceptions save to the error return register and raise the error-level flag. Debug exceptions save to the debug return register and enter debug mode. The block registers every result, so the redirect appears one cycle after the request.

Top module: `exc_entry_seq`

## Requirements
- R1: Apart from a debug single step, the saved return address (`save_addr`) is `req_pc` minus 4 when `req_in_ds` is 1, and `req_pc` when it is 0.
- R2: A debug single step (kind 5) saves `req_pc` unchanged, whatever `req_in_ds` says.
- R3: For a normal-class request, `cause_out` bit 31 equals `req_in_ds` and bits 6..2 equal `req_code`. Every other Cause bit keeps its value from `cause_in`.
- R4: A normal-class request reports class 0. It sets Status bit 1 (exception level) and leaves every other Status bit and the Debug register unchanged. Kinds 0, 11, 12, 13, 14 and 15 are general exceptions.
- R5: The vector of a normal-class request is a base plus an offset. The base is 0xBFC00200 when Status bit 22 (bootstrap vectors) is 1, and 0x80000000 when it is 0. A general exception uses offset 0x180.
- R6: A TLB refill (kind 2) uses offset 0x000 when Status bit 1 is 0, and offset 0x180 when it is 1.
- R7: An external interrupt (kind 1) outside debug mode uses offset 0x200 when Cause bit 23 is 1, and offset 0x180 when it is 0.
- R8: Reset (kind 3) reports class 1, sets Status to exactly 0x10400004 (bits 28, 22 and 2) and vectors to 0xBFC00000. A non-maskable error (kind 4) reports class 1, ORs bits 22 and 2 into Status and uses the same vector. Neither of them changes Cause.
- R9: Debug kinds report class 2, set `debug_mode_out`, vector to 0xBFC00480, leave Status and Cause unchanged, and OR one Debug bit into `debug_in`. The bits are: single step (5) bit 0, breakpoint (8) bit 1, data load break (10) bit 2, data store break (9) bit 3, instruction break (7) bit 4, debug interrupt (6) bit 5.
- R10: An external interrupt (kind 1) that arrives while `debug_mode_in` is 1 is handled exactly as a debug interrupt: class 2 and Debug bit 5.
- R11: `out_valid` is 1 in the cycle after a clock edge that sampled `req_valid` as 1, and 0 otherwise. Synchronous reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present |
| req_kind | input | 4 | Exception kind |
| req_code | input | 5 | Cause code for normal-class requests |
| req_pc | input | 32 | PC of the excepting instruction |
| req_in_ds | input | 1 | Instruction was in a branch delay slot |
| debug_mode_in | input | 1 | Core is currently in debug mode |
| status_in | input | 32 | Current Status register |
| cause_in | input | 32 | Current Cause register |
| debug_in | input | 32 | Current Debug register |
| out_valid | output | 1 | Redirect and register updates valid |
| out_class | output | 2 | 0 normal, 1 error, 2 debug (selects the save register) |
| save_addr | output | 32 | Return address to store |
| vector_pc | output | 32 | PC to fetch from |
| status_out | output | 32 | New Status value |
| cause_out | output | 32 | New Cause value |
| debug_out | output | 32 | New Debug value |
| debug_mode_out | output | 1 | Debug mode after entry |

## Verification
All state in this block is a single output register stage, so any fault in classification, address arithmetic or field merging shows up at the ports in the cycle right after the request that caused it. A wrong class decode sends the redirect to the wrong save register and the wrong vector. A wrong mask shows up either as a Cause or Status bit that was not preserved, or as the wrong Debug bit. A stuck or late valid register shows up as a missing or extra redirect in the next cycle. Because the bench sends requests back to back, a result that leaks from one request into the next is caught at once.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN = 32;
    localparam int CODE_W = 5;

    // Status bit positions
    localparam int ST_CU0 = 28;
    localparam int ST_BEV = 22;
    localparam int ST_ERL = 2;
    localparam int ST_EXL = 1;

    // Cause bit positions
    localparam int CA_BD      = 31;
    localparam int CA_IV      = 23;
    localparam int CA_CODE_LO = 2;
    localparam int CA_CODE_HI = CA_CODE_LO + CODE_W - 1;

    // Debug bit positions
    localparam int DB_SSTEP  = 0;
    localparam int DB_BRKPT  = 1;
    localparam int DB_DLOAD  = 2;
    localparam int DB_DSTORE = 3;
    localparam int DB_IBRK   = 4;
    localparam int DB_INT    = 5;

    typedef enum logic [3:0] {
        KIND_GENERAL    = 4'd0,
        KIND_EXT_INT    = 4'd1,
        KIND_TLB_REFILL = 4'd2,
        KIND_RESET      = 4'd3,
        KIND_NMI        = 4'd4,
        KIND_DBG_SSTEP  = 4'd5,
        KIND_DBG_INT    = 4'd6,
        KIND_DBG_IBRK   = 4'd7,
        KIND_DBG_BRKPT  = 4'd8,
        KIND_DBG_DSTORE = 4'd9,
        KIND_DBG_DLOAD  = 4'd10
    } exc_kind_e;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ERROR  = 2'd1,
        CLS_DEBUG  = 2'd2
    } exc_class_e;

    typedef struct packed {
        exc_class_e       cls;
        logic             is_reset;
        logic             is_sstep;
        logic             is_refill;
        logic             is_intr;
        logic [XLEN-1:0]  dbg_mask;
    } exc_decode_t;

    typedef struct packed {
        logic             valid;
        exc_class_e       cls;
        logic [XLEN-1:0]  save_addr;
        logic [XLEN-1:0]  vector;
        logic [XLEN-1:0]  status;
        logic [XLEN-1:0]  cause;
        logic [XLEN-1:0]  debug;
        logic             dm;
    } exc_entry_t;

    function automatic logic [XLEN-1:0] bit_mask(input int pos);
        logic [XLEN-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

    function automatic logic [XLEN-1:0] return_addr(
        input logic [XLEN-1:0] pc,
        input logic            in_ds,
        input logic            sstep,
        input logic [XLEN-1:0] insn_bytes
    );
        if (sstep || !in_ds) begin
            return pc;
        end
        return pc - insn_bytes;
    endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
(
    input  logic [3:0]    kind,
    input  logic          debug_mode,
    output exc_decode_t   dec
);

    exc_kind_e eff;

    always_comb begin
        eff = exc_kind_e'(kind);
        if (kind == KIND_EXT_INT && debug_mode) begin
            eff = KIND_DBG_INT;
        end
    end

    always_comb begin
        dec = '0;
        dec.cls = CLS_NORMAL;
        case (eff)
            KIND_EXT_INT:    dec.is_intr   = 1'b1;
            KIND_TLB_REFILL: dec.is_refill = 1'b1;
            KIND_RESET: begin
                dec.cls      = CLS_ERROR;
                dec.is_reset = 1'b1;
            end
            KIND_NMI:        dec.cls = CLS_ERROR;
            KIND_DBG_SSTEP: begin
                dec.cls      = CLS_DEBUG;
                dec.is_sstep = 1'b1;
                dec.dbg_mask = bit_mask(DB_SSTEP);
            end
            KIND_DBG_INT: begin
                dec.cls      = CLS_DEBUG;
                dec.dbg_mask = bit_mask(DB_INT);
            end
            KIND_DBG_IBRK: begin
                dec.cls      = CLS_DEBUG;
                dec.dbg_mask = bit_mask(DB_IBRK);
            end
            KIND_DBG_BRKPT: begin
                dec.cls      = CLS_DEBUG;
                dec.dbg_mask = bit_mask(DB_BRKPT);
            end
            KIND_DBG_DSTORE: begin
                dec.cls      = CLS_DEBUG;
                dec.dbg_mask = bit_mask(DB_DSTORE);
            end
            KIND_DBG_DLOAD: begin
                dec.cls      = CLS_DEBUG;
                dec.dbg_mask = bit_mask(DB_DLOAD);
            end
            default:         dec.cls = CLS_NORMAL;
        endcase
    end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_RESET   = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] VEC_DEBUG   = 32'hBFC0_0480,
    parameter logic [XLEN-1:0] BASE_BOOT   = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] BASE_NORMAL = 32'h8000_0000,
    parameter logic [XLEN-1:0] OFF_REFILL  = 32'h0000_0000,
    parameter logic [XLEN-1:0] OFF_GENERAL = 32'h0000_0180,
    parameter logic [XLEN-1:0] OFF_INTR    = 32'h0000_0200
) (
    input  exc_decode_t      dec,
    input  logic             bev,
    input  logic             exl,
    input  logic             iv,
    output logic [XLEN-1:0]  vector
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base = bev ? BASE_BOOT : BASE_NORMAL;
        if (dec.is_refill && !exl) begin
            offset = OFF_REFILL;
        end else if (dec.is_intr && iv) begin
            offset = OFF_INTR;
        end else begin
            offset = OFF_GENERAL;
        end
    end

    always_comb begin
        unique case (dec.cls)
            CLS_ERROR: vector = VEC_RESET;
            CLS_DEBUG: vector = VEC_DEBUG;
            default:   vector = base + offset;
        endcase
    end

endmodule

// File: rtl/exc_reg_update.sv
module exc_reg_update
    import exc_pkg::*;
(
    input  exc_decode_t        dec,
    input  logic [CODE_W-1:0]  code,
    input  logic               in_ds,
    input  logic               debug_mode,
    input  logic [XLEN-1:0]    status_in,
    input  logic [XLEN-1:0]    cause_in,
    input  logic [XLEN-1:0]    debug_in,
    output logic [XLEN-1:0]    status_nx,
    output logic [XLEN-1:0]    cause_nx,
    output logic [XLEN-1:0]    debug_nx,
    output logic               dm_nx
);

    localparam logic [XLEN-1:0] RESET_STATUS =
        (XLEN'(1) << ST_CU0) | (XLEN'(1) << ST_BEV) | (XLEN'(1) << ST_ERL);
    localparam logic [XLEN-1:0] ERR_SET =
        (XLEN'(1) << ST_BEV) | (XLEN'(1) << ST_ERL);

    always_comb begin
        status_nx = status_in;
        cause_nx  = cause_in;
        debug_nx  = debug_in;
        unique case (dec.cls)
            CLS_NORMAL: begin
                status_nx[ST_EXL]                 = 1'b1;
                cause_nx[CA_CODE_HI:CA_CODE_LO]   = code;
                cause_nx[CA_BD]                   = in_ds;
            end
            CLS_ERROR: begin
                status_nx = dec.is_reset ? RESET_STATUS : (status_in | ERR_SET);
            end
            CLS_DEBUG: begin
                debug_nx = debug_in | dec.dbg_mask;
            end
            default: ;
        endcase
        dm_nx = debug_mode || (dec.cls == CLS_DEBUG);
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter logic [31:0] VEC_RESET   = 32'hBFC0_0000,
    parameter logic [31:0] VEC_DEBUG   = 32'hBFC0_0480,
    parameter logic [31:0] BASE_BOOT   = 32'hBFC0_0200,
    parameter logic [31:0] BASE_NORMAL = 32'h8000_0000,
    parameter logic [31:0] OFF_REFILL  = 32'h0000_0000,
    parameter logic [31:0] OFF_GENERAL = 32'h0000_0180,
    parameter logic [31:0] OFF_INTR    = 32'h0000_0200,
    parameter int          INSN_BYTES  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  req_kind,
    input  logic [4:0]  req_code,
    input  logic [31:0] req_pc,
    input  logic        req_in_ds,
    input  logic        debug_mode_in,
    input  logic [31:0] status_in,
    input  logic [31:0] cause_in,
    input  logic [31:0] debug_in,
    output logic        out_valid,
    output logic [1:0]  out_class,
    output logic [31:0] save_addr,
    output logic [31:0] vector_pc,
    output logic [31:0] status_out,
    output logic [31:0] cause_out,
    output logic [31:0] debug_out,
    output logic        debug_mode_out
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    exc_decode_t      dec;
    logic [XLEN-1:0]  vec_nx;
    logic [XLEN-1:0]  status_nx;
    logic [XLEN-1:0]  cause_nx;
    logic [XLEN-1:0]  debug_nx;
    logic             dm_nx;
    exc_entry_t       nx;
    exc_entry_t       q;

    exc_classify u_classify (
        .kind       (req_kind),
        .debug_mode (debug_mode_in),
        .dec        (dec)
    );

    exc_vector_sel #(
        .VEC_RESET   (VEC_RESET),
        .VEC_DEBUG   (VEC_DEBUG),
        .BASE_BOOT   (BASE_BOOT),
        .BASE_NORMAL (BASE_NORMAL),
        .OFF_REFILL  (OFF_REFILL),
        .OFF_GENERAL (OFF_GENERAL),
        .OFF_INTR    (OFF_INTR)
    ) u_vector (
        .dec    (dec),
        .bev    (status_in[ST_BEV]),
        .exl    (status_in[ST_EXL]),
        .iv     (cause_in[CA_IV]),
        .vector (vec_nx)
    );

    exc_reg_update u_regs (
        .dec        (dec),
        .code       (req_code),
        .in_ds      (req_in_ds),
        .debug_mode (debug_mode_in),
        .status_in  (status_in),
        .cause_in   (cause_in),
        .debug_in   (debug_in),
        .status_nx  (status_nx),
        .cause_nx   (cause_nx),
        .debug_nx   (debug_nx),
        .dm_nx      (dm_nx)
    );

    always_comb begin
        nx.valid     = req_valid;
        nx.cls       = dec.cls;
        nx.save_addr = return_addr(req_pc, req_in_ds, dec.is_sstep, STEP);
        nx.vector    = vec_nx;
        nx.status    = status_nx;
        nx.cause     = cause_nx;
        nx.debug     = debug_nx;
        nx.dm        = dm_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.cls <= CLS_NORMAL;
        end else begin
            q.valid <= req_valid;
            if (req_valid) begin
                q <= nx;
            end
        end
    end

    assign out_valid      = q.valid;
    assign out_class      = q.cls;
    assign save_addr      = q.save_addr;
    assign vector_pc      = q.vector;
    assign status_out     = q.status;
    assign cause_out      = q.cause;
    assign debug_out      = q.debug;
    assign debug_mode_out = q.dm;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [3:0]  req_kind,
    input logic [31:0] req_pc,
    input logic        req_in_ds,
    input logic        debug_mode_in,
    input logic        out_valid,
    input logic [1:0]  out_class,
    input logic [31:0] save_addr,
    input logic [31:0] vector_pc,
    input logic [31:0] status_out,
    input logic [31:0] debug_out,
    input logic        debug_mode_out
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R11

    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid); // R11

    AST_RET_PLAIN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_in_ds) |=> (save_addr == $past(req_pc))); // R1

    AST_RET_SSTEP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 4'd5) |=> (save_addr == $past(req_pc))); // R2

    AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_class != 2'd3)); // R4

    AST_NORMAL_EXL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == 2'd0) |-> status_out[1]); // R4

    AST_DEBUG_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == 2'd2) |-> (vector_pc == 32'hBFC0_0480 && debug_mode_out)); // R9

    AST_DM_INTR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 4'd1 && debug_mode_in) |=> (out_class == 2'd2 && debug_out[5])); // R10

endmodule

bind exc_entry_seq exc_entry_seq_chk chk_i (.*);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic [4:0]  req_code = '0;
    logic [31:0] req_pc = '0;
    logic        req_in_ds = 1'b0;
    logic        debug_mode_in = 1'b0;
    logic [31:0] status_in = '0;
    logic [31:0] cause_in = '0;
    logic [31:0] debug_in = '0;
    logic        out_valid;
    logic [1:0]  out_class;
    logic [31:0] save_addr;
    logic [31:0] vector_pc;
    logic [31:0] status_out;
    logic [31:0] cause_out;
    logic [31:0] debug_out;
    logic        debug_mode_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic [1:0]  cls;
        logic [31:0] sav;
        logic [31:0] vec;
        logic [31:0] st;
        logic [31:0] ca;
        logic [31:0] db;
        logic        dm;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    exc_entry_seq dut_i (.*);

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [3:0] k, input logic [4:0] code, input logic [31:0] pc,
                                   input logic ds, input logic [31:0] st, input logic [31:0] ca,
                                   input logic [31:0] db, input logic dm, input string tag);
        exp_t e;
        logic [3:0] kk;
        logic [31:0] off;
        kk = (k == 4'd1 && dm) ? 4'd6 : k;
        e.tag = tag;
        e.st = st; e.ca = ca; e.db = db; e.dm = dm;
        e.sav = (ds && kk != 4'd5) ? pc - 32'd4 : pc;
        if (kk == 4'd3 || kk == 4'd4) begin
            e.cls = 2'd1;
            e.vec = 32'hBFC0_0000;
            e.st  = (kk == 4'd3) ? 32'h1040_0004 : (st | 32'h0040_0004);
        end else if (kk >= 4'd5 && kk <= 4'd10) begin
            e.cls = 2'd2;
            e.vec = 32'hBFC0_0480;
            e.dm  = 1'b1;
            case (kk)
                4'd5:    e.db = db | 32'h01;
                4'd8:    e.db = db | 32'h02;
                4'd10:   e.db = db | 32'h04;
                4'd9:    e.db = db | 32'h08;
                4'd7:    e.db = db | 32'h10;
                default: e.db = db | 32'h20;
            endcase
        end else begin
            e.cls = 2'd0;
            e.st  = st | 32'h2;
            e.ca  = {ds, ca[30:7], code, ca[1:0]};
            if (kk == 4'd2 && !st[1])      off = 32'h000;
            else if (kk == 4'd1 && ca[23]) off = 32'h200;
            else                           off = 32'h180;
            e.vec = (st[22] ? 32'hBFC0_0200 : 32'h8000_0000) + off;
        end
        return e;
    endfunction

    task automatic send(input logic [3:0] k, input logic [4:0] code, input logic [31:0] pc,
                        input logic ds, input logic [31:0] st, input logic [31:0] ca,
                        input logic [31:0] db, input logic dm, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_code = code; req_pc = pc; req_in_ds = ds;
        status_in = st; cause_in = ca; debug_in = db; debug_mode_in = dm;
        exp_q.push_back(model(k, code, pc, ds, st, ca, db, dm, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_kind  = 4'hF;
        end
    endtask

    // monitor: compares results one settle step after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check("R11", "unexpected valid", 32'd1, 32'd0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(e.tag, "class", 32'(out_class), 32'(e.cls));
                        check(e.tag, "save_addr", save_addr, e.sav);
                        check(e.tag, "vector", vector_pc, e.vec);
                        check(e.tag, "status", status_out, e.st);
                        check(e.tag, "cause", cause_out, e.ca);
                        check(e.tag, "debug", debug_out, e.db);
                        check(e.tag, "debug_mode", 32'(debug_mode_out), 32'(e.dm));
                    end
                end else if (exp_q.size() != 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R11", "missing valid", 32'd0, 32'd1);
                end
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected fewer than 5000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11", "valid in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R11", "valid after reset", 32'(out_valid), 32'd0);

        // R1 R3 R4 R5 general exceptions
        send(4'd0,  5'd5,  32'h0040_1000, 1'b0, 32'h0000_0010, 32'h8000_FF00, 32'h0, 1'b0, "R3");
        send(4'd12, 5'd10, 32'h0040_2004, 1'b1, 32'h0040_0000, 32'h7FFF_FF83, 32'h0, 1'b0, "R1");
        send(4'd13, 5'd31, 32'h1234_5678, 1'b0, 32'hFFBF_FFFD, 32'hFFFF_FFFF, 32'hA5, 1'b0, "R4");
        send(4'd0,  5'd0,  32'h0000_0008, 1'b0, 32'h0040_0000, 32'h0, 32'h0, 1'b0, "R5");
        idle(2);
        // R6 refill
        send(4'd2, 5'd2, 32'h0000_3000, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, "R6");
        send(4'd2, 5'd3, 32'h0000_3004, 1'b1, 32'h0000_0002, 32'h0, 32'h0, 1'b0, "R6");
        send(4'd2, 5'd2, 32'h0000_3008, 1'b0, 32'h0040_0000, 32'h0, 32'h0, 1'b0, "R6");
        // R7 interrupts
        send(4'd1, 5'd0, 32'h0000_4000, 1'b0, 32'h0, 32'h0080_0000, 32'h0, 1'b0, "R7");
        send(4'd1, 5'd0, 32'h0000_4004, 1'b1, 32'h0, 32'h0000_0000, 32'h0, 1'b0, "R7");
        send(4'd1, 5'd0, 32'h0000_4008, 1'b0, 32'h0040_0000, 32'h0080_0000, 32'h0, 1'b0, "R7");
        idle(1);
        // R8 error class
        send(4'd3, 5'd9, 32'h0000_5000, 1'b1, 32'h0000_FF13, 32'h1234_0000, 32'h0, 1'b0, "R8");
        send(4'd4, 5'd9, 32'h0000_5004, 1'b0, 32'h0000_FF11, 32'h0000_007C, 32'h0, 1'b0, "R8");
        // R9 debug kinds, R2 single step
        send(4'd5,  5'd0, 32'h0000_6000, 1'b1, 32'h11, 32'h22, 32'h4000_0000, 1'b0, "R2");
        send(4'd6,  5'd0, 32'h0000_6004, 1'b1, 32'h11, 32'h22, 32'h0, 1'b0, "R9");
        send(4'd7,  5'd0, 32'h0000_6008, 1'b0, 32'h11, 32'h22, 32'h0, 1'b0, "R9");
        send(4'd8,  5'd0, 32'h0000_600C, 1'b1, 32'h11, 32'h22, 32'h0, 1'b0, "R9");
        send(4'd9,  5'd0, 32'h0000_6010, 1'b0, 32'h11, 32'h22, 32'h0, 1'b0, "R9");
        send(4'd10, 5'd0, 32'h0000_6014, 1'b0, 32'h11, 32'h22, 32'h100, 1'b0, "R9");
        // R10 interrupt in debug mode
        send(4'd1, 5'd0, 32'h0000_7000, 1'b1, 32'h0, 32'h0080_0000, 32'h0, 1'b1, "R10");
        // unknown kinds act as general
        send(4'd15, 5'd7, 32'h0000_8000, 1'b0, 32'h0, 32'h0, 32'h0, 1'b0, "R4");
        idle(3);
        check("R11", "idle valid", 32'(out_valid), 32'd0);
        check("R11", "queue drained", 32'(exp_q.size()), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule